// File: doc/BRIEF.md
# Timed Fragmenting Channel

This block models a one-way, single-sender, single-receiver link for cycle-accurate emulation of a larger system. A whole message enters at the sender port. The block cuts it into fixed-width pieces and puts one piece on the modelled wire in each target cycle, lowest piece first. The pieces pass through a delay of a configured number of target cycles. They then wait in a bounded store until a reassembler rebuilds the full message and offers it to the receiver. A target cycle that carries no piece still appears on the wire as an idle slot, so the far side sees time pass even when no data moves. In this model one clock edge is one target cycle.

The three timing knobs are set independently. Bandwidth is the piece width in bits. Latency is the wire delay in target cycles. Buffering is the capacity counted in pieces. A debug port can slip whole messages into the stream, and a monitor tap shows every wire slot as it leaves the delay stage.

Top module: `tfc_channel`

## Requirements
- R1: Every accepted message reaches `rx_msg` unchanged, and messages leave in the order they were accepted, counting both sender and debug-port messages.
- R2: A message of MSG_W bits is carried as MSG_W/FRAG_W pieces in consecutive target cycles. Piece k holds bits [k*FRAG_W +: FRAG_W], and only the final piece has `mon_frag_eom` set to 1.
- R3: Each wire slot carries at most one piece. A slot with no piece shows `mon_frag_vld`=0 with `mon_frag_eom`=0 and `mon_frag_data`=0.
- R4: Piece k of a message accepted in cycle c appears on the monitor tap in cycle c+1+k+LATENCY. With an empty channel and `rx_ready` high, `rx_valid` rises in cycle c+NFRAG+LATENCY+2.
- R5: While a message is being cut, both ready outputs are low, except in the cycle that emits its last piece. In that cycle a new message may be accepted, so back-to-back acceptances are NFRAG cycles apart.
- R6: A message is accepted only if the occupancy plus NFRAG is at most BUF_FRAGS. Occupancy counts the pieces that have been accepted but not yet taken by the reassembler. With the receiver stalled and default parameters, exactly three messages are accepted.
- R7: `rx_valid` rises only after a last piece has reached the reassembler. While `rx_ready` is low it stays high and `rx_msg` stays unchanged.
- R8: When the debug port and the sender both request at a message boundary, the debug message is taken and `tx_ready` stays low in that cycle. Pieces of two messages never interleave.
- R9: After reset, `tx_ready` and `inj_ready` are 1, and `rx_valid` and `mon_frag_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per target cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Sender offers a message |
| tx_ready | output | 1 | Sender message accepted this cycle if valid |
| tx_msg | input | MSG_W | Sender message |
| inj_valid | input | 1 | Debug port offers a message |
| inj_ready | output | 1 | Debug message accepted this cycle if valid |
| inj_msg | input | MSG_W | Debug message |
| rx_valid | output | 1 | Reassembled message available |
| rx_ready | input | 1 | Receiver takes the message |
| rx_msg | output | MSG_W | Reassembled message |
| mon_frag_vld | output | 1 | Wire slot carries a piece (0 = idle slot) |
| mon_frag_eom | output | 1 | Piece is the last of its message |
| mon_frag_data | output | FRAG_W | Piece contents, zero in idle slots |

## Verification
Two events can fall in the same cycle. A new message can be accepted in the cycle that emits the last piece of the previous one, and the debug port and the sender can both request at that same boundary. The bench provokes this by raising both requests while the channel is still cutting the previous vector, so the decision lands in the last-piece cycle. The outcome is judged in two ways. The bench checks which handshake comes first, and a scoreboard compares every reassembled message against the order the rules predict, which would expose interleaved or dropped pieces.

// File: rtl/tfc_pkg.sv
// Shared definitions for the timed fragmenting channel.
package tfc_pkg;
    // Number of wire pieces needed for one message.
    function automatic int frag_count(input int msg_w, input int frag_w);
        return (msg_w + frag_w - 1) / frag_w;
    endfunction

    // Per-slot marker travelling beside piece data.
    typedef struct packed {
        logic vld;   // slot carries a piece
        logic eom;   // piece closes its message
    } tag_t;
endpackage

// File: rtl/tfc_splitter.sv
// Accepts whole messages from the sender or the debug port and emits one
// piece per cycle, lowest piece first. Assumes MSG_W is a multiple of FRAG_W.
// Arbitration happens only at a message boundary; debug wins ties.
module tfc_splitter
    import tfc_pkg::*;
#(
    parameter int MSG_W  = 32,
    parameter int FRAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [MSG_W-1:0]  tx_msg,
    input  logic              inj_valid,
    input  logic [MSG_W-1:0]  inj_msg,
    input  logic              room_ok,
    output logic              tx_ready,
    output logic              inj_ready,
    output logic              accept,
    output tag_t              frag_tag,
    output logic [FRAG_W-1:0] frag_data
);
    localparam int NFRAG = frag_count(MSG_W, FRAG_W);
    localparam int IW    = (NFRAG > 1) ? $clog2(NFRAG) : 1;
    localparam int PW    = NFRAG * FRAG_W;

    logic [PW-1:0]    hold_q;
    logic [IW-1:0]    idx_q;
    logic             busy_q;
    logic             last;
    logic             boundary;
    logic [MSG_W-1:0] sel_msg;

    // Boundary detection and tie-breaking between the two sources.
    always_comb begin
        last      = busy_q && (idx_q == IW'(NFRAG - 1));
        boundary  = !busy_q || last;
        inj_ready = boundary && room_ok;
        tx_ready  = boundary && room_ok && !inj_valid;
        accept    = (inj_valid && inj_ready) || (tx_valid && tx_ready);
        sel_msg   = inj_valid ? inj_msg : tx_msg;
    end

    // Hold the message being cut and step through its pieces.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (accept) begin
            hold_q <= PW'(sel_msg);
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            hold_q <= hold_q >> FRAG_W;
            idx_q  <= idx_q + IW'(1);
            if (last) busy_q <= 1'b0;
        end
    end

    // Present the current piece, or a clean idle slot.
    always_comb begin
        frag_tag.vld = busy_q;
        frag_tag.eom = last;
        frag_data    = busy_q ? hold_q[FRAG_W-1:0] : '0;
    end

    // R8: a new message starts at piece zero in the cycle after acceptance.
    p_start_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy_q && idx_q == '0));

    // R5: while not at a boundary, neither source can be accepted.
    p_no_midmsg_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last) |-> !(tx_ready || inj_ready));
endmodule

// File: rtl/tfc_delay.sv
// Fixed wire delay: every slot, piece or idle, moves one stage per cycle.
// Assumes LATENCY >= 1.
module tfc_delay
    import tfc_pkg::*;
#(
    parameter int W       = 8,
    parameter int LATENCY = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tag_t         in_tag,
    input  logic [W-1:0] in_data,
    output tag_t         out_tag,
    output logic [W-1:0] out_data
);
    localparam int SW = W + 2;

    logic [SW-1:0] stg_q [LATENCY];

    // Shift every slot one stage toward the far end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LATENCY; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= {in_tag, in_data};
            for (int i = 1; i < LATENCY; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    // Split the last stage back into marker and data.
    always_comb begin
        out_tag  = tag_t'(stg_q[LATENCY-1][SW-1:W]);
        out_data = stg_q[LATENCY-1][W-1:0];
    end

    // R3: idle slots leave the wire with no marker bits and no data.
    p_idle_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_tag.vld |-> (!out_tag.eom && out_data == '0));
endmodule

// File: rtl/tfc_fifo.sv
// Bounded piece store between the wire and the reassembler. The caller's
// credit scheme guarantees it is never pushed while full.
module tfc_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
    end

    // Pointer and fill-level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Head of queue is visible without a read cycle.
    always_comb begin
        empty = (cnt_q == '0);
        head  = mem[rd_q];
    end

    // R6: the credit scheme must keep the store from overrunning.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < CW'(DEPTH) || pop));

    // R7: the reassembler never draws from an empty store.
    p_no_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tfc_joiner.sv
// Rebuilds messages from pieces, lowest first, and holds a finished message
// until the receiver takes it. Stops drawing pieces while holding.
module tfc_joiner
    import tfc_pkg::*;
#(
    parameter int MSG_W  = 32,
    parameter int FRAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              avail,
    input  logic [FRAG_W-1:0] head_data,
    input  logic              head_eom,
    input  logic              rx_ready,
    output logic              pop,
    output logic              rx_valid,
    output logic [MSG_W-1:0]  rx_msg
);
    localparam int NFRAG = frag_count(MSG_W, FRAG_W);
    localparam int PW    = NFRAG * FRAG_W;

    logic [PW-1:0] asm_q;
    logic          done_q;

    // Draw a piece when not blocked by an untaken message.
    always_comb begin
        pop      = avail && (!done_q || rx_ready);
        rx_valid = done_q;
        rx_msg   = asm_q[MSG_W-1:0];
    end

    // Shift pieces in from the top; flag completion on the last piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (pop) asm_q <= (asm_q >> FRAG_W) | (PW'(head_data) << (PW - FRAG_W));
            if (pop && head_eom) done_q <= 1'b1;
            else if (rx_ready)   done_q <= 1'b0;
        end
    end

    // R7: a message is offered only after its closing piece was drawn.
    p_valid_after_eom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(pop && head_eom));

    // R7: an untaken message stays put.
    p_hold_until_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !rx_ready) |=> (done_q && $stable(asm_q)));
endmodule

// File: rtl/tfc_channel.sv
// Timed fragmenting channel: splitter -> wire delay -> bounded store ->
// reassembler. One clock edge is one target cycle. A whole message's worth
// of credit is reserved at acceptance, so cutting never stalls mid-message.
module tfc_channel
    import tfc_pkg::*;
#(
    parameter int MSG_W     = 32,
    parameter int FRAG_W    = 8,
    parameter int LATENCY   = 3,
    parameter int BUF_FRAGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [MSG_W-1:0]  tx_msg,
    input  logic              inj_valid,
    output logic              inj_ready,
    input  logic [MSG_W-1:0]  inj_msg,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [MSG_W-1:0]  rx_msg,
    output logic              mon_frag_vld,
    output logic              mon_frag_eom,
    output logic [FRAG_W-1:0] mon_frag_data
);
    localparam int NFRAG = frag_count(MSG_W, FRAG_W);
    localparam int CW    = $clog2(BUF_FRAGS + NFRAG + 1);

    logic              accept, room_ok, pop, empty;
    tag_t              sp_tag, wire_tag;
    logic [FRAG_W-1:0] sp_data, wire_data;
    logic [FRAG_W:0]   head;
    logic [CW-1:0]     occ_q;

    // Room for a full message under the piece budget.
    always_comb begin
        room_ok = ({1'b0, occ_q} + (CW+1)'(NFRAG)) <= (CW+1)'(BUF_FRAGS);
    end

    // Occupancy: pieces accepted but not yet drawn by the reassembler.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_q + (accept ? CW'(NFRAG) : '0) - CW'(pop);
    end

    tfc_splitter #(.MSG_W(MSG_W), .FRAG_W(FRAG_W)) u_split (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_msg(tx_msg),
        .inj_valid(inj_valid), .inj_msg(inj_msg),
        .room_ok(room_ok), .tx_ready(tx_ready), .inj_ready(inj_ready),
        .accept(accept), .frag_tag(sp_tag), .frag_data(sp_data)
    );

    tfc_delay #(.W(FRAG_W), .LATENCY(LATENCY)) u_wire (
        .clk(clk), .rst_n(rst_n),
        .in_tag(sp_tag), .in_data(sp_data),
        .out_tag(wire_tag), .out_data(wire_data)
    );

    tfc_fifo #(.W(FRAG_W + 1), .DEPTH(BUF_FRAGS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(wire_tag.vld), .push_data({wire_tag.eom, wire_data}),
        .pop(pop), .empty(empty), .head(head)
    );

    tfc_joiner #(.MSG_W(MSG_W), .FRAG_W(FRAG_W)) u_join (
        .clk(clk), .rst_n(rst_n),
        .avail(!empty), .head_data(head[FRAG_W-1:0]), .head_eom(head[FRAG_W]),
        .rx_ready(rx_ready), .pop(pop), .rx_valid(rx_valid), .rx_msg(rx_msg)
    );

    // Monitor tap on the far end of the wire.
    always_comb begin
        mon_frag_vld  = wire_tag.vld;
        mon_frag_eom  = wire_tag.eom;
        mon_frag_data = wire_data;
    end

    // R6: occupancy never exceeds the configured piece budget.
    p_budget_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CW'(BUF_FRAGS));

    // R8: when the debug port is taken, its lowest piece goes out next.
    p_inj_first_piece_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && inj_ready) |=> (sp_tag.vld && sp_data == $past(inj_msg[FRAG_W-1:0])));
endmodule

// File: tb/tfc_channel_bench.sv
module tfc_channel_bench;
    localparam int MSG_W = 32, FRAG_W = 8, LAT = 3, BUF = 8, NF = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n, tx_valid, tx_ready, inj_valid, inj_ready;
    logic              rx_valid, rx_ready, mon_frag_vld, mon_frag_eom;
    logic [MSG_W-1:0]  tx_msg, inj_msg, rx_msg;
    logic [FRAG_W-1:0] mon_frag_data;

    tfc_channel #(.MSG_W(MSG_W), .FRAG_W(FRAG_W), .LATENCY(LAT), .BUF_FRAGS(BUF)) u_tfc_channel (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_msg(tx_msg),
        .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_msg(inj_msg),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_msg(rx_msg),
        .mon_frag_vld(mon_frag_vld), .mon_frag_eom(mon_frag_eom), .mon_frag_data(mon_frag_data)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [MSG_W-1:0] expq [$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // R1 scoreboard: deliveries must follow the predicted order.
    always @(negedge clk) begin : sb
        logic [MSG_W-1:0] e;
        if (rst_n && rx_valid && rx_ready) begin
            if (expq.size() == 0) check(1'b0, "R1 unexpected delivery", rx_msg, 0);
            else begin
                e = expq.pop_front();
                check(rx_msg == e, "R1 order and content", rx_msg, e);
            end
        end
    end

    typedef struct packed {
        logic             use_inj;
        logic             use_tx;
        logic [MSG_W-1:0] inj_m;
        logic [MSG_W-1:0] tx_m;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 32'h0000_0000, 32'h1234_5678},
        '{1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0000_0000},
        '{1'b1, 1'b1, 32'hCAFE_0001, 32'h0BAD_F00D},
        '{1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
        '{1'b1, 1'b1, 32'h5555_AAAA, 32'h0000_0000},
        '{1'b1, 1'b1, 32'h8000_0001, 32'h7E7E_8181}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [MSG_W-1:0] m;
        logic [MSG_W-1:0] bp [4];
        int idx, got, gap;
        rst_n = 1'b0; tx_valid = 0; inj_valid = 0; tx_msg = '0; inj_msg = '0; rx_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(tx_ready && inj_ready, "R9 readies after reset", {tx_ready, inj_ready}, 2'b11);
        check(!rx_valid && !mon_frag_vld, "R9 outputs idle after reset", {rx_valid, mon_frag_vld}, 0);

        // Table walk: R1 order, R8 priority at boundary, R5 back-to-back.
        for (int v = 0; v < 6; v++) begin
            bit need_i, need_t, first, hi, ht;
            need_i = VECS[v].use_inj; need_t = VECS[v].use_tx; first = 1;
            if (need_i) expq.push_back(VECS[v].inj_m);
            if (need_t) expq.push_back(VECS[v].tx_m);
            inj_valid = need_i; inj_msg = VECS[v].inj_m;
            tx_valid  = need_t; tx_msg  = VECS[v].tx_m;
            for (int w = 0; w < 40 && (need_i || need_t); w++) begin
                #1;
                hi = inj_valid && inj_ready;
                ht = tx_valid && tx_ready;
                if (first && (hi || ht)) begin
                    first = 0;
                    if (need_i) check(hi && !ht, "R8 debug message wins boundary", {hi, ht}, 2'b10);
                end
                @(negedge clk);
                if (hi) begin inj_valid = 0; need_i = 0; end
                if (ht) begin tx_valid = 0; need_t = 0; end
            end
            check(!need_i && !need_t, "R1 vector accepted", {need_i, need_t}, 0);
        end
        repeat (40) @(negedge clk);
        check(expq.size() == 0, "R1 table fully delivered", expq.size(), 0);

        // Exact timing from an empty channel: R2, R3, R4, R5.
        m = 32'hA1B2_C3D4;
        expq.push_back(m);
        tx_msg = m; tx_valid = 1'b1;
        #1 check(tx_ready, "R4 ready on empty channel", tx_ready, 1);
        @(negedge clk);
        tx_valid = 1'b0;
        for (int j = 1; j <= NF + LAT + 4; j++) begin
            bit ev, ee, er;
            logic [FRAG_W-1:0] ed;
            ev = (j >= 1 + LAT) && (j <= LAT + NF);
            ed = ev ? m[(j-1-LAT)*FRAG_W +: FRAG_W] : '0;
            ee = (j == LAT + NF);
            er = (j == NF + LAT + 2);
            check(mon_frag_vld == ev && mon_frag_data == ed && mon_frag_eom == ee,
                  "R2 R3 R4 wire slot", {mon_frag_vld, mon_frag_eom, mon_frag_data}, {ev, ee, ed});
            check(rx_valid == er, "R4 R7 delivery cycle", rx_valid, er);
            if (j < NF)  check(!tx_ready, "R5 ready low mid-message", tx_ready, 0);
            if (j == NF) check(tx_ready, "R5 ready on last piece", tx_ready, 1);
            @(negedge clk);
        end

        // R5 back-to-back spacing of acceptances.
        repeat (10) @(negedge clk);
        expq.push_back(32'h1111_2222); expq.push_back(32'h3333_4444);
        tx_msg = 32'h1111_2222; tx_valid = 1'b1; got = 0; gap = 0;
        for (int w = 0; w < 20 && got < 2; w++) begin
            #1;
            if (tx_ready) begin
                got++;
                if (got == 1) gap = 0;
                else check(gap == NF, "R5 back-to-back spacing", gap, NF);
            end
            @(negedge clk);
            if (got == 1) tx_msg = 32'h3333_4444;
            if (got == 2) tx_valid = 1'b0;
            gap++;
        end
        check(got == 2, "R5 both accepted", got, 2);
        repeat (20) @(negedge clk);

        // R6 budget and R7 hold with a stalled receiver.
        bp[0] = 32'hB0B0_0000; bp[1] = 32'hB1B1_1111; bp[2] = 32'hB2B2_2222; bp[3] = 32'hB3B3_3333;
        rx_ready = 1'b0; idx = 0; tx_msg = bp[0]; tx_valid = 1'b1;
        for (int w = 0; w < 60; w++) begin
            #1;
            if (tx_valid && tx_ready) begin expq.push_back(tx_msg); idx++; end
            @(negedge clk);
            if (idx < 4) tx_msg = bp[idx]; else tx_valid = 1'b0;
        end
        check(idx == 3, "R6 acceptances under stall", idx, 3);
        #1 check(!tx_ready, "R6 ready low at budget", tx_ready, 0);
        check(rx_valid && rx_msg == bp[0], "R7 first message held", rx_msg, bp[0]);
        @(negedge clk);
        check(rx_valid && rx_msg == bp[0], "R7 held across stall", rx_msg, bp[0]);
        rx_ready = 1'b1;
        for (int w = 0; w < 40 && idx < 4; w++) begin
            #1;
            if (tx_valid && tx_ready) begin expq.push_back(tx_msg); idx++; end
            @(negedge clk);
            if (idx >= 4) tx_valid = 1'b0;
        end
        tx_valid = 1'b0;
        check(idx == 4, "R6 accepts after drain", idx, 4);
        repeat (40) @(negedge clk);
        check(expq.size() == 0, "R1 stalled set delivered in order", expq.size(), 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule